// File: doc/BRIEF.md
# Descriptor Ring Walker for an Audio DMA Channel

This block steps through a circular ring of eight-byte buffer descriptors in memory for one audio DMA channel. It reads each entry as two 32-bit words through a simple request/response memory port. It then hands the buffer address and remaining sample count to the data path. As the data path reports transferred bytes, the block counts down the remaining samples. When an entry runs out, the block either moves on to the next ring slot or stops, depending on whether the finished slot is the host's last valid slot.

Each completion pulses a one-cycle status update toward the register block. That block applies its own interrupt enables. When a playback channel has stopped at the end of the ring but is still enabled, this block supplies fill samples. Each descriptor carries a flag that chooses the fill: either the last sample moved or silence. The host lets a stopped channel continue by rewriting the last valid slot number.

Top module: `bdl_sequencer`

## Requirements
- R1: After reset, `cur_idx`=0, `pre_idx`=1, `halted`=1, `at_last`=0, and `mem_req`, `sts_upd`, `xfer_ok` and `fill_valid` are all 0.
- R2: An entry is read as two words. The low word is read at `base_addr + 8*cur_idx` and the high word at that address plus 4. The high word is requested only after the low word has returned. A request holds its address until `mem_rdy` accepts it.
- R3: Once an entry with a nonzero length is loaded, `buf_addr` equals the low word with bits 1:0 cleared. `remaining` equals bits 15:0 of the high word, in 16-bit samples. Bit 31 of the high word asks for a completion flag, and bit 30 selects repeat-last fill.
- R4: `xfer_ok` is high only while an entry is loaded and running. A `xfer_valid` pulse outside that state changes neither `remaining`, the status strobes nor the fill sample.
- R5: Each accepted transfer lowers `remaining` by `xfer_bytes` shifted right by one. The count stops at zero rather than going below it.
- R6: An entry that empties produces exactly one `sts_upd` pulse. `sts_val` is packed as [3] buffer done, [2] last buffer done, [1] at last, [0] halted, and bit 3 copies the entry's bit 31. When `cur_idx` differs from `last_idx`, bits 2:0 are 0, `cur_idx` takes `pre_idx`, and the next entry is fetched.
- R7: When the emptied entry's index equals `last_idx`, `sts_val` bits 2:0 are all 1. The outputs `halted` and `at_last` go high, and no further fetch is made.
- R8: A fetched entry with zero length and an index different from `last_idx` is skipped. No status pulse is made, and the following slot is fetched.
- R9: A fetched entry with zero length whose index equals `last_idx` halts the channel. It produces one `sts_upd` with `sts_val` = 4'b0001.
- R10: `pre_idx` always equals `cur_idx + 1` modulo 2^IDX_W, so slot 31 is followed by slot 0.
- R11: While halted with `run` high on a playback channel, `fill_valid` is 1. `fill_sample` is the last accepted `xfer_sample` if the final entry had bit 30 set, and 0 otherwise.
- R12: A `last_idx_wr` pulse while halted with `run` high clears `halted`, loads `cur_idx` from `pre_idx` and fetches that slot.
- R13: With `run` low, the channel goes idle: `xfer_ok`, `fill_valid` and new requests are 0. Raising `run` again refetches the slot at `cur_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Channel enable |
| base_addr | input | ADDR_W | Ring base address |
| last_idx | input | IDX_W | Last valid slot |
| last_idx_wr | input | 1 | Pulse: host rewrote `last_idx` |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read address |
| mem_rdy | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| xfer_valid | input | 1 | Data path moved bytes this cycle |
| xfer_bytes | input | XB_W | Bytes moved |
| xfer_sample | input | SMP_W | Last stereo sample moved |
| xfer_ok | output | 1 | Data path may transfer |
| buf_addr | output | ADDR_W | Current buffer address |
| remaining | output | 16 | Samples left in current entry |
| cur_idx | output | IDX_W | Current slot |
| pre_idx | output | IDX_W | Next slot |
| halted | output | 1 | Channel stopped |
| at_last | output | 1 | Stopped on last valid slot |
| sts_upd | output | 1 | One-cycle status update strobe |
| sts_val | output | 4 | Status value carried by the strobe |
| fill_valid | output | 1 | Fill samples active |
| fill_sample | output | SMP_W | Fill sample value |

## Verification
The hardest cases to reach are the slot wrap from 31 to 0 and a zero-length entry sitting exactly on the last valid slot. Both need the channel to walk more than one full ring with the right host rewrites in between. The bench gets there by first stopping at slot 3. It then rewrites the last slot to 1, so the walk runs through the top of the ring, wraps, and passes a zero-length entry on the way. It then rewrites the last slot to 9, where the zero-length entry halts the channel. Finally it drops and raises `run` to show that the same halt repeats on refetch.

// File: rtl/bdl_pkg.sv
package bdl_pkg;

   localparam int LEN_BITS = 16;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_FETCH,
      SQ_XFER,
      SQ_HALT,
      SQ_DRAIN
   } seq_state_e;

   typedef enum logic [2:0] {
      FT_IDLE,
      FT_REQ_LO,
      FT_WAIT_LO,
      FT_REQ_HI,
      FT_WAIT_HI
   } fetch_state_e;

   typedef struct packed {
      logic buf_done;
      logic last_done;
      logic at_last;
      logic halted;
   } chan_status_t;

endpackage

// File: rtl/bdl_fetch.sv
module bdl_fetch
   import bdl_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [ADDR_W-1:0]   base,
   input  logic [IDX_W-1:0]    idx,
   output logic                mem_req,
   output logic [ADDR_W-1:0]   mem_addr,
   input  logic                mem_rdy,
   input  logic                mem_rvalid,
   input  logic [31:0]         mem_rdata,
   output logic                busy,
   output logic                done,
   output logic [ADDR_W-1:0]   d_addr,
   output logic [LEN_BITS-1:0] d_len,
   output logic                d_ioc,
   output logic                d_bup
);

   localparam int ENTRY_SHIFT = 3;
   localparam logic [ADDR_W-1:0] HI_OFS = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

   generate
      if (ADDR_W < IDX_W + ENTRY_SHIFT || ADDR_W > 32) begin : g_bad_addr_w
         $error("bdl_fetch: ADDR_W must cover the ring and fit a 32-bit word");
      end
   endgenerate

   fetch_state_e          st;
   logic [ADDR_W-1:0]     entry_q;
   logic [31:0]           lo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= FT_IDLE;
         entry_q <= '0;
         lo_q    <= '0;
      end else begin
         case (st)
            FT_IDLE: if (start) begin
               entry_q <= base + (ADDR_W'(idx) << ENTRY_SHIFT);
               st      <= FT_REQ_LO;
            end
            FT_REQ_LO:  if (mem_rdy) st <= FT_WAIT_LO;
            FT_WAIT_LO: if (mem_rvalid) begin
               lo_q <= mem_rdata;
               st   <= FT_REQ_HI;
            end
            FT_REQ_HI:  if (mem_rdy) st <= FT_WAIT_HI;
            FT_WAIT_HI: if (mem_rvalid) st <= FT_IDLE;
            default:    st <= FT_IDLE;
         endcase
      end
   end

   assign mem_req  = (st == FT_REQ_LO) || (st == FT_REQ_HI);
   assign mem_addr = (st == FT_REQ_HI) ? entry_q + HI_OFS : entry_q;
   assign busy     = (st != FT_IDLE);
   assign done     = (st == FT_WAIT_HI) && mem_rvalid;
   assign d_addr   = ADDR_W'(lo_q) & ALIGN_MASK;
   assign d_len    = mem_rdata[LEN_BITS-1:0];
   assign d_ioc    = mem_rdata[31];
   assign d_bup    = mem_rdata[30];

endmodule

// File: rtl/bdl_countdown.sv
module bdl_countdown
   import bdl_pkg::*;
#(
   parameter int XB_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic [LEN_BITS-1:0] load_val,
   input  logic                take,
   input  logic [XB_W-1:0]     bytes,
   output logic [LEN_BITS-1:0] remaining,
   output logic                empties
);

   localparam int CMP_W = (LEN_BITS > XB_W) ? LEN_BITS : XB_W;

   generate
      if (XB_W < 2) begin : g_bad_xb_w
         $error("bdl_countdown: XB_W must be at least 2");
      end
   endgenerate

   logic [LEN_BITS-1:0] rem_q;
   logic [XB_W-1:0]     smp;
   logic [CMP_W-1:0]    rem_x;
   logic [CMP_W-1:0]    smp_x;
   logic                covers;

   assign smp     = bytes >> 1;
   assign rem_x   = CMP_W'(rem_q);
   assign smp_x   = CMP_W'(smp);
   assign covers  = smp_x >= rem_x;
   assign empties = take && (rem_q != '0) && covers;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
      end else if (load) begin
         rem_q <= load_val;
      end else if (take) begin
         rem_q <= covers ? '0 : rem_q - LEN_BITS'(smp_x);
      end
   end

   assign remaining = rem_q;

endmodule

// File: rtl/bdl_fill.sv
module bdl_fill #(
   parameter bit PLAYBACK = 1'b1,
   parameter int SMP_W    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [SMP_W-1:0] sample_in,
   input  logic             pol_set,
   input  logic             pol_val,
   input  logic             active,
   output logic             fill_valid,
   output logic [SMP_W-1:0] fill_sample
);

   generate
      if (PLAYBACK) begin : g_play
         logic [SMP_W-1:0] last_q;
         logic             pol_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               last_q <= '0;
               pol_q  <= 1'b0;
            end else begin
               if (capture) last_q <= sample_in;
               if (pol_set) pol_q  <= pol_val;
            end
         end

         assign fill_valid  = active;
         assign fill_sample = (active && pol_q) ? last_q : '0;
      end else begin : g_capture_only
         logic unused_fill;
         assign unused_fill = ^{clk, rst_n, capture, sample_in, pol_set, pol_val, active};
         assign fill_valid  = 1'b0;
         assign fill_sample = '0;
      end
   endgenerate

endmodule

// File: rtl/bdl_sequencer.sv
module bdl_sequencer
   import bdl_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int IDX_W    = 5,
   parameter int XB_W     = 16,
   parameter int SMP_W    = 32,
   parameter bit PLAYBACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [IDX_W-1:0]  last_idx,
   input  logic              last_idx_wr,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rdy,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   input  logic              xfer_valid,
   input  logic [XB_W-1:0]   xfer_bytes,
   input  logic [SMP_W-1:0]  xfer_sample,
   output logic              xfer_ok,
   output logic [ADDR_W-1:0] buf_addr,
   output logic [15:0]       remaining,
   output logic [IDX_W-1:0]  cur_idx,
   output logic [IDX_W-1:0]  pre_idx,
   output logic              halted,
   output logic              at_last,
   output logic              sts_upd,
   output logic [3:0]        sts_val,
   output logic              fill_valid,
   output logic [SMP_W-1:0]  fill_sample
);

   localparam logic [IDX_W-1:0] IDX_STEP = IDX_W'(1);

   generate
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx_w
         $error("bdl_sequencer: IDX_W out of range");
      end
      if (SMP_W < 1) begin : g_bad_smp_w
         $error("bdl_sequencer: SMP_W must be positive");
      end
   endgenerate

   seq_state_e            st;
   logic [IDX_W-1:0]      cur_q;
   logic [IDX_W-1:0]      pre_q;
   logic                  halted_q;
   logic                  at_last_q;
   logic                  ioc_q;
   logic                  bup_q;
   logic [ADDR_W-1:0]     baddr_q;
   logic                  kick_q;
   logic                  upd_q;
   chan_status_t          sts_q;

   logic                  f_busy;
   logic                  f_done;
   logic [ADDR_W-1:0]     d_addr;
   logic [LEN_BITS-1:0]   d_len;
   logic                  d_ioc;
   logic                  d_bup;

   logic                  take;
   logic                  empties;
   logic                  load;
   logic                  on_last;
   logic                  pol_set;
   logic                  fill_on;

   assign take    = (st == SQ_XFER) && run && xfer_valid;
   assign load    = (st == SQ_FETCH) && run && f_done && (d_len != '0);
   assign on_last = (cur_q == last_idx);
   assign pol_set = (st == SQ_XFER) && empties && on_last;
   assign fill_on = (st == SQ_HALT) && halted_q && run;

   bdl_fetch #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (kick_q),
      .base       (base_addr),
      .idx        (cur_q),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rdy    (mem_rdy),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .busy       (f_busy),
      .done       (f_done),
      .d_addr     (d_addr),
      .d_len      (d_len),
      .d_ioc      (d_ioc),
      .d_bup      (d_bup)
   );

   bdl_countdown #(
      .XB_W (XB_W)
   ) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_val  (d_len),
      .take      (take),
      .bytes     (xfer_bytes),
      .remaining (remaining),
      .empties   (empties)
   );

   bdl_fill #(
      .PLAYBACK (PLAYBACK),
      .SMP_W    (SMP_W)
   ) u_fill (
      .clk         (clk),
      .rst_n       (rst_n),
      .capture     (take),
      .sample_in   (xfer_sample),
      .pol_set     (pol_set),
      .pol_val     (bup_q),
      .active      (fill_on),
      .fill_valid  (fill_valid),
      .fill_sample (fill_sample)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= SQ_IDLE;
         cur_q     <= '0;
         pre_q     <= IDX_STEP;
         halted_q  <= 1'b1;
         at_last_q <= 1'b0;
         ioc_q     <= 1'b0;
         bup_q     <= 1'b0;
         baddr_q   <= '0;
         kick_q    <= 1'b0;
         upd_q     <= 1'b0;
         sts_q     <= '0;
      end else begin
         kick_q <= 1'b0;
         upd_q  <= 1'b0;
         case (st)
            SQ_IDLE: begin
               if (run && !f_busy) begin
                  halted_q  <= 1'b0;
                  at_last_q <= 1'b0;
                  kick_q    <= 1'b1;
                  st        <= SQ_FETCH;
               end
            end
            SQ_FETCH: begin
               if (!run) begin
                  st <= SQ_DRAIN;
               end else if (f_done) begin
                  if (d_len == '0) begin
                     if (on_last) begin
                        halted_q <= 1'b1;
                        upd_q    <= 1'b1;
                        sts_q    <= '{buf_done: 1'b0, last_done: 1'b0,
                                     at_last: at_last_q, halted: 1'b1};
                        st       <= SQ_HALT;
                     end else begin
                        cur_q  <= pre_q;
                        pre_q  <= pre_q + IDX_STEP;
                        kick_q <= 1'b1;
                     end
                  end else begin
                     baddr_q <= d_addr;
                     ioc_q   <= d_ioc;
                     bup_q   <= d_bup;
                     st      <= SQ_XFER;
                  end
               end
            end
            SQ_XFER: begin
               if (!run) begin
                  st <= SQ_IDLE;
               end else if (empties) begin
                  upd_q <= 1'b1;
                  if (on_last) begin
                     halted_q  <= 1'b1;
                     at_last_q <= 1'b1;
                     sts_q     <= '{buf_done: ioc_q, last_done: 1'b1,
                                    at_last: 1'b1, halted: 1'b1};
                     st        <= SQ_HALT;
                  end else begin
                     at_last_q <= 1'b0;
                     sts_q     <= '{buf_done: ioc_q, last_done: 1'b0,
                                    at_last: 1'b0, halted: 1'b0};
                     cur_q     <= pre_q;
                     pre_q     <= pre_q + IDX_STEP;
                     kick_q    <= 1'b1;
                     st        <= SQ_FETCH;
                  end
               end
            end
            SQ_HALT: begin
               if (!run) begin
                  st <= SQ_IDLE;
               end else if (last_idx_wr) begin
                  cur_q     <= pre_q;
                  pre_q     <= pre_q + IDX_STEP;
                  halted_q  <= 1'b0;
                  at_last_q <= 1'b0;
                  kick_q    <= 1'b1;
                  st        <= SQ_FETCH;
               end
            end
            SQ_DRAIN: begin
               if (!f_busy) st <= SQ_IDLE;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   assign xfer_ok  = (st == SQ_XFER);
   assign buf_addr = baddr_q;
   assign cur_idx  = cur_q;
   assign pre_idx  = pre_q;
   assign halted   = halted_q;
   assign at_last  = at_last_q;
   assign sts_upd  = upd_q;
   assign sts_val  = sts_q;

endmodule

// File: rtl/bdl_sequencer_chk.sv
module bdl_sequencer_chk #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              run,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_rdy,
   input logic              xfer_valid,
   input logic              xfer_ok,
   input logic [15:0]       remaining,
   input logic [IDX_W-1:0]  cur_idx,
   input logic [IDX_W-1:0]  pre_idx,
   input logic              halted,
   input logic              at_last,
   input logic              sts_upd,
   input logic [3:0]        sts_val,
   input logic              fill_valid
);

   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr)));

   // R2
   no_fetch_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_ok |-> !mem_req);

   // R4
   no_xfer_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> !xfer_ok);

   // R5
   count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_ok && !xfer_valid) |=> $stable(remaining));

   // R6
   single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sts_upd |=> !sts_upd);

   // R7
   last_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_upd && sts_val[2]) |-> (halted && at_last && !xfer_ok));

   // R10
   next_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre_idx == cur_idx + IDX_W'(1));

   // R11
   fill_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> (halted && run));

endmodule

bind bdl_sequencer bdl_sequencer_chk #(
   .ADDR_W (ADDR_W),
   .IDX_W  (IDX_W)
) u_bdl_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .run        (run),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_rdy    (mem_rdy),
   .xfer_valid (xfer_valid),
   .xfer_ok    (xfer_ok),
   .remaining  (remaining),
   .cur_idx    (cur_idx),
   .pre_idx    (pre_idx),
   .halted     (halted),
   .at_last    (at_last),
   .sts_upd    (sts_upd),
   .sts_val    (sts_val),
   .fill_valid (fill_valid)
);

// File: tb/test_bdl_sequencer.sv
module test_bdl_sequencer;

   localparam logic [31:0] BASE = 32'h0001_2340;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        run;
   logic [4:0]  last_idx;
   logic        last_idx_wr;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_rdy;
   logic        mem_rvalid;
   logic [31:0] mem_rdata;
   logic        xfer_valid;
   logic [15:0] xfer_bytes;
   logic [31:0] xfer_sample;
   logic        xfer_ok;
   logic [31:0] buf_addr;
   logic [15:0] remaining;
   logic [4:0]  cur_idx;
   logic [4:0]  pre_idx;
   logic        halted;
   logic        at_last;
   logic        sts_upd;
   logic [3:0]  sts_val;
   logic        fill_valid;
   logic [31:0] fill_sample;

   int          total = 0;
   int          bad = 0;
   int          n_str = 0;
   int          exp_str = 0;
   logic [3:0]  last_sts = '0;
   logic [31:0] last_smp = '0;
   int          smp_ctr = 0;
   bit          flip = 1'b0;

   always #10 clk = ~clk;

   bdl_sequencer i_bdl_sequencer (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (run),
      .base_addr   (BASE),
      .last_idx    (last_idx),
      .last_idx_wr (last_idx_wr),
      .mem_req     (mem_req),
      .mem_addr    (mem_addr),
      .mem_rdy     (mem_rdy),
      .mem_rvalid  (mem_rvalid),
      .mem_rdata   (mem_rdata),
      .xfer_valid  (xfer_valid),
      .xfer_bytes  (xfer_bytes),
      .xfer_sample (xfer_sample),
      .xfer_ok     (xfer_ok),
      .buf_addr    (buf_addr),
      .remaining   (remaining),
      .cur_idx     (cur_idx),
      .pre_idx     (pre_idx),
      .halted      (halted),
      .at_last     (at_last),
      .sts_upd     (sts_upd),
      .sts_val     (sts_val),
      .fill_valid  (fill_valid),
      .fill_sample (fill_sample)
   );

   function automatic int dlen(int i);
      return (i == 2 || i == 9) ? 0 : (i % 4) + 1;
   endfunction

   function automatic bit dioc(int i);
      return (i % 2) == 0;
   endfunction

   function automatic bit dbup(int i);
      return i == 3;
   endfunction

   function automatic logic [31:0] w0(int i);
      return 32'h4000_0003 + 32'(i) * 32'h100;
   endfunction

   function automatic logic [31:0] w1(int i);
      return {dioc(i), dbup(i), 14'h1555, 16'(dlen(i))};
   endfunction

   function automatic logic [31:0] rd_word(logic [31:0] a);
      logic [31:0] ofs;
      int k;
      ofs = a - BASE;
      k = int'(ofs >> 3) & 31;
      return ofs[2] ? w1(k) : w0(k);
   endfunction

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(negedge clk);
   endtask

   // memory responder: accepts on mem_rdy, answers two cycles later
   initial begin
      int   pend = 0;
      int   cyc = 0;
      bit   phase = 1'b0;
      logic [31:0] paddr = '0;
      mem_rdy = 1'b0;
      mem_rvalid = 1'b0;
      mem_rdata = '0;
      forever begin
         @(negedge clk);
         cyc++;
         mem_rvalid = 1'b0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               mem_rvalid = 1'b1;
               mem_rdata = rd_word(paddr);
            end
         end
         mem_rdy = (cyc % 3) != 0;
         if (rst_n && mem_req && mem_rdy) begin
            // R2: word address from slot and word order
            chk("R2", mem_addr, BASE + 32'(cur_idx) * 8 + (phase ? 32'd4 : 32'd0));
            paddr = mem_addr;
            phase = !phase;
            pend = 2;
         end
      end
   end

   // strobe monitor, sampled between edges
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sts_upd === 1'b1) begin
            n_str++;
            last_sts = sts_val;
         end
      end
   end

   task automatic wait_ok;
      int n = 0;
      while (xfer_ok !== 1'b1 && n < 400) begin
         tick;
         n++;
      end
   endtask

   task automatic wait_strobe(int target);
      int n = 0;
      while (n_str < target && n < 400) begin
         tick;
         n++;
      end
   endtask

   task automatic serve(int i, bit is_last);
      int rem;
      int b;
      logic [31:0] smp;
      wait_ok;
      chk("R10 slot", 64'(cur_idx), 64'(i));
      chk("R3 length", 64'(remaining), 64'(dlen(i)));
      chk("R3 address", 64'(buf_addr), 64'(w0(i) & 32'hFFFF_FFFC));
      chk("R8 no strobe", 64'(n_str), 64'(exp_str));
      rem = dlen(i);
      while (rem > 0) begin
         b = flip ? 5 : 4;
         flip = !flip;
         smp = 32'hC0DE_0000 + 32'(smp_ctr);
         smp_ctr++;
         xfer_valid = 1'b1;
         xfer_bytes = 16'(b);
         xfer_sample = smp;
         tick;
         xfer_valid = 1'b0;
         rem = (rem > b / 2) ? rem - b / 2 : 0;
         last_smp = smp;
         chk("R5 count", 64'(remaining), 64'(rem));
      end
      exp_str++;
      chk("R6 strobe", 64'(n_str), 64'(exp_str));
      chk(is_last ? "R7 status" : "R6 status", 64'(last_sts),
          64'({dioc(i), is_last, is_last, is_last}));
      chk("R7 halted", 64'(halted), 64'(is_last));
      if (!is_last) chk("R6 next", 64'(cur_idx), 64'((i + 1) % 32));
   endtask

   initial begin
      rst_n = 1'b0;
      run = 1'b0;
      last_idx = 5'd3;
      last_idx_wr = 1'b0;
      xfer_valid = 1'b0;
      xfer_bytes = '0;
      xfer_sample = '0;
      repeat (3) tick;
      rst_n = 1'b1;
      tick;
      // R1
      chk("R1 cur", 64'(cur_idx), 64'd0);
      chk("R1 pre", 64'(pre_idx), 64'd1);
      chk("R1 halted", 64'(halted), 64'd1);
      chk("R1 at_last", 64'(at_last), 64'd0);
      chk("R1 outputs", 64'({mem_req, sts_upd, xfer_ok, fill_valid}), 64'd0);

      // first walk: 0, 1, skip 2, stop at 3 (repeat-last fill)
      run = 1'b1;
      serve(0, 1'b0);
      serve(1, 1'b0);
      serve(3, 1'b1);
      tick;
      chk("R7 at_last", 64'(at_last), 64'd1);
      chk("R11 fill on", 64'(fill_valid), 64'd1);
      chk("R11 repeat", 64'(fill_sample), 64'(last_smp));

      // R4: transfer pulse while stopped is ignored
      xfer_valid = 1'b1;
      xfer_bytes = 16'd8;
      xfer_sample = 32'hDEAD_BEEF;
      tick;
      xfer_valid = 1'b0;
      tick;
      chk("R4 count", 64'(remaining), 64'd0);
      chk("R4 strobe", 64'(n_str), 64'(exp_str));
      chk("R4 fill", 64'(fill_sample), 64'(last_smp));

      // R12: resume, walk through wrap to slot 1 (zero fill)
      last_idx = 5'd1;
      last_idx_wr = 1'b1;
      tick;
      last_idx_wr = 1'b0;
      chk("R12 halted", 64'(halted), 64'd0);
      chk("R12 cur", 64'(cur_idx), 64'd4);
      for (int k = 4; k < 34; k++) begin
         if (dlen(k % 32) != 0) serve(k % 32, (k % 32) == 1);
      end
      tick;
      chk("R11 fill on", 64'(fill_valid), 64'd1);
      chk("R11 zeros", 64'(fill_sample), 64'd0);

      // R9: zero-length entry on the last slot
      last_idx = 5'd9;
      last_idx_wr = 1'b1;
      tick;
      last_idx_wr = 1'b0;
      for (int k = 3; k < 9; k++) serve(k, 1'b0);
      wait_strobe(exp_str + 1);
      exp_str++;
      tick;
      chk("R9 strobe", 64'(n_str), 64'(exp_str));
      chk("R9 status", 64'(last_sts), 64'h1);
      chk("R9 cur", 64'(cur_idx), 64'd9);
      chk("R9 halted", 64'(halted), 64'd1);

      // R13: drop run, then restart refetches slot 9
      run = 1'b0;
      tick;
      tick;
      chk("R13 idle", 64'({fill_valid, xfer_ok, mem_req}), 64'd0);
      run = 1'b1;
      wait_strobe(exp_str + 1);
      exp_str++;
      tick;
      chk("R13 restart", 64'(n_str), 64'(exp_str));
      chk("R13 status", 64'(last_sts), 64'h1);
      chk("R13 cur", 64'(cur_idx), 64'd9);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (60000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule